// File: doc/BRIEF.md
# Splittable Sixteen-Bit Up-Counter

This block is a synchronous up-counter built from two equal halves, a low half and a high half. In normal operation the halves form one wide counter: the high half advances only when the low half rolls over. When the split select is high, the link between the halves is cut. Each half then counts on the count enable by itself, on the same clock. An exhaustive pass over each half then needs a few hundred pulses where the joined counter needs tens of thousands.

A parallel preload places any chosen value in the counter in one cycle. Tests of neighbouring logic can then start from a known count without stepping up to it. A synchronous reset clears every flop. Reset wins over preload, and preload wins over counting. Each half raises its own terminal-count flag at all ones. A full-width terminal-count flag is raised only when the counter is joined and holds all ones.

All pins are plain control and status lines sampled on the single clock. There is no stream traffic and no handshake. The split select is an ordinary data input and is not registered: its level at a clock edge decides how that edge counts.

Top module: `split_counter`

## Requirements
- R1: When `rst` is high at a clock edge, `count_q` is 16'h0000 after that edge, whatever `load_en` and `cnt_en` are.
- R2: When `rst` is low and `load_en` is high at an edge, `count_q` equals `load_val` after that edge, whether or not `cnt_en` is high.
- R3: With `rst` and `load_en` low and `split_sel` low, each edge with `cnt_en` high adds one to `count_q` modulo 2^16, so 16'hFFFF goes to 16'h0000.
- R4: With `split_sel` low, the high byte `count_q[15:8]` changes on a counting edge only when the low byte was 8'hFF.
- R5: With `split_sel` high, every counting edge adds one to each byte separately, modulo 2^8. The low byte wrapping from 8'hFF does not carry into the high byte, and the high byte wraps from 8'hFF to 8'h00 on its own.
- R6: When `rst`, `load_en` and `cnt_en` are all low at an edge, `count_q` does not change.
- R7: `lo_tc` is high exactly when `count_q[7:0]` is 8'hFF, and `hi_tc` is high exactly when `count_q[15:8]` is 8'hFF, in either mode.
- R8: `full_tc` is high exactly when `count_q` is 16'hFFFF and `split_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| split_sel | input | 1 | High: halves count independently |
| load_en | input | 1 | Preload strobe |
| load_val | input | 16 | Value taken on preload |
| count_q | output | 16 | Registered count; bits 7:0 low half, 15:8 high half |
| lo_tc | output | 1 | Low half at all ones |
| hi_tc | output | 1 | High half at all ones |
| full_tc | output | 1 | Joined counter at all ones |

## Verification
Reset, preload and counting each show on `count_q` one clock after the edge that samples them, because only the count register sits between input and output. The three terminal-count flags decode that register combinationally. `full_tc` also follows `split_sel` with no delay. The bench drives inputs a quarter period after a rising edge. It waits for the next rising edge and compares a quarter period later, so every expected value is the state one edge after the drive. The flags are compared in the same window as the count that produces them.

// File: rtl/split_counter_pkg.sv
package split_counter_pkg;
  typedef enum logic {
    MODE_JOINED = 1'b0,
    MODE_SPLIT  = 1'b1
  } link_mode_e;

  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/ctr_half.sv
module ctr_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] q_next;

  always_comb begin
    if (rst)       q_next = '0;
    else if (load) q_next = load_val;
    else if (inc)  q_next = q + ONE;
    else           q_next = q;
  end

  always_ff @(posedge clk) q <= q_next;

  assign tc = (q == ALL_ONES);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == '0);
  a_r2_load_takes: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(load_val));
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (!load && inc) |=> q == $past(q) + ONE);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(q));
endmodule

// File: rtl/ctr_link.sv
module ctr_link
  import split_counter_pkg::*;
(
  input  logic       cnt_en,
  input  link_mode_e mode,
  input  logic       lo_tc,
  output logic       lo_inc,
  output logic       hi_inc
);
  always_comb begin
    lo_inc = cnt_en;
    unique case (mode)
      MODE_SPLIT:  hi_inc = cnt_en;
      default:     hi_inc = cnt_en & lo_tc;
    endcase
  end
endmodule

// File: rtl/split_counter.sv
module split_counter
  import split_counter_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_en,
  input  logic                  split_sel,
  input  logic                  load_en,
  input  logic [2*HALF_W-1:0]   load_val,
  output logic [2*HALF_W-1:0]   count_q,
  output logic                  lo_tc,
  output logic                  hi_tc,
  output logic                  full_tc
);
  localparam int unsigned FULL_W = NUM_HALVES * HALF_W;

  link_mode_e            mode;
  logic [NUM_HALVES-1:0] half_inc;
  logic [NUM_HALVES-1:0] half_tc;

  assign mode = split_sel ? MODE_SPLIT : MODE_JOINED;

  ctr_link u_link (
    .cnt_en (cnt_en),
    .mode   (mode),
    .lo_tc  (half_tc[0]),
    .lo_inc (half_inc[0]),
    .hi_inc (half_inc[1])
  );

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    ctr_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst      (rst),
      .load     (load_en),
      .load_val (load_val[g*HALF_W +: HALF_W]),
      .inc      (half_inc[g]),
      .q        (count_q[g*HALF_W +: HALF_W]),
      .tc       (half_tc[g])
    );
  end

  assign lo_tc   = half_tc[0];
  assign hi_tc   = half_tc[1];
  assign full_tc = (mode == MODE_JOINED) & half_tc[0] & half_tc[1];

  a_r4_no_early_carry: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !split_sel && !lo_tc) |=>
      count_q[FULL_W-1:HALF_W] == $past(count_q[FULL_W-1:HALF_W]));
  a_r5_split_upper: assert property (@(posedge clk) disable iff (rst)
    (!load_en && split_sel && cnt_en) |=>
      count_q[FULL_W-1:HALF_W] == $past(count_q[FULL_W-1:HALF_W]) + 1'b1);
  a_r8_full_flag: assert property (@(posedge clk)
    full_tc |-> (count_q == {FULL_W{1'b1}} && !split_sel));
endmodule

// File: tb/split_counter_test.sv
module split_counter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst, cnt_en, split_sel, load_en;
  logic [15:0] load_val;
  logic [15:0] count_q;
  logic        lo_tc, hi_tc, full_tc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  split_counter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .split_sel(split_sel),
    .load_en(load_en), .load_val(load_val), .count_q(count_q),
    .lo_tc(lo_tc), .hi_tc(hi_tc), .full_tc(full_tc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req, logic [15:0] c, logic split);
    check({req, " lo_tc"}, {15'd0, lo_tc}, {15'd0, c[7:0] == 8'hFF});
    check({req, " hi_tc"}, {15'd0, hi_tc}, {15'd0, c[15:8] == 8'hFF});
    check({req, " full_tc"}, {15'd0, full_tc},
          {15'd0, (c == 16'hFFFF) && !split});
  endtask

  task automatic preload(logic [15:0] v);
    load_en = 1'b1; load_val = v; cnt_en = 1'b0;
    tick();
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; load_en = 1'b1; load_val = 16'hABCD; cnt_en = 1'b1; split_sel = 1'b0;
    tick(); tick();
    check("R1 reset beats load", count_q, 16'h0000);
    check_flags("R7 reset", count_q, 1'b0);
    rst = 1'b0; load_en = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic t_load();
    load_en = 1'b1; cnt_en = 1'b1; load_val = 16'h1234;
    tick();
    check("R2 load beats count", count_q, 16'h1234);
    load_en = 1'b0; cnt_en = 1'b0;
    tick();
    check("R6 hold when idle", count_q, 16'h1234);
  endtask

  task automatic t_joined();
    split_sel = 1'b0;
    preload(16'h20FE);
    cnt_en = 1'b1; tick();
    check("R3 joined step", count_q, 16'h20FF);
    check_flags("R7 low at ones", count_q, 1'b0);
    tick();
    check("R4 carry into high byte", count_q, 16'h2100);
    tick();
    check("R4 no carry below ones", count_q, 16'h2101);
    cnt_en = 1'b0;
    preload(16'hFFFE);
    cnt_en = 1'b1; tick();
    check("R3 reach all ones", count_q, 16'hFFFF);
    check_flags("R8 joined all ones", count_q, 1'b0);
    tick();
    check("R3 wrap to zero", count_q, 16'h0000);
    cnt_en = 1'b0;
  endtask

  task automatic t_split();
    split_sel = 1'b1;
    preload(16'h05FE);
    cnt_en = 1'b1; tick();
    check("R5 split both step", count_q, 16'h06FF);
    tick();
    check("R5 low wrap no carry", count_q, 16'h0700);
    cnt_en = 1'b0;
    preload(16'hFF10);
    cnt_en = 1'b1; tick();
    check("R5 high wraps alone", count_q, 16'h0011);
    cnt_en = 1'b0;
    preload(16'h0000);
    cnt_en = 1'b1;
    for (int i = 0; i < 255; i++) tick();
    cnt_en = 1'b0;
    check("R5 exhaustive half pass", count_q, 16'hFFFF);
    check_flags("R8 split masks full", count_q, 1'b1);
    split_sel = 1'b0;
    #1;
    check_flags("R8 joined unmasks full", count_q, 1'b0);
    tick();
    check("R6 hold after split", count_q, 16'hFFFF);
  endtask

  initial begin
    rst = 1'b1; cnt_en = 1'b0; split_sel = 1'b0; load_en = 1'b0; load_val = '0;
    #(CLK_PERIOD/4);
    t_reset();
    t_load();
    t_joined();
    t_split();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule